// File: doc/BRIEF.md
# DMA Channel Address Stepper

This block holds the current source and destination addresses of one DMA channel and moves them forward after every transfer unit. A control word chooses, for each side, whether the address stays put, counts up or counts down. It also chooses the transfer unit size: one byte, a 2-byte word, a 4-byte longword or a 16-byte line. Channel logic elsewhere loads the starting addresses, programs the control word and pulses a strobe once per completed unit. The two registered address outputs then carry the addresses for the next unit.

The block treats line transfers on the source side differently. When the size is the 16-byte line, the source address always moves up by 16, whatever its mode field holds. The destination address keeps following its own mode. For single address transfers, a pair of qualifier inputs marks which side is the external device that answers with an acknowledge. The address on that side is then frozen.

A full chip standby clears the control word. A module-level standby freezes it.

Top module: `dma_addr_step`

## Requirements
- R1: After reset the control read port returns 0, so both modes are fixed and the size is byte, and both address outputs are 0.
- R2: A control write, with neither standby input high, stores bits 15:0 of the write data. The read port then returns those 16 bits in bits 15:0, and bits 31:16 always read as 0.
- R3: When the load strobe is high, both addresses take the load values on the next clock, even if the transfer strobe is high in the same cycle.
- R4: The destination mode sits in control bits 15:14. It is applied on each transfer strobe: 00 keeps the address, 01 adds the step, 10 subtracts the step, and 11 keeps the address.
- R5: The source mode sits in control bits 13:12 and uses the same encoding as the destination mode. This holds for every size except the 16-byte line.
- R6: The transfer size sits in control bits 11:10. The codes 00, 01, 10 and 11 give a step of 1, 2, 4 and 16 bytes.
- R7: With size code 11, each transfer strobe adds 16 to the source address for all four source mode codes. The destination address still follows its own mode.
- R8: Address arithmetic wraps modulo 2^32 in both directions.
- R9: While the chip standby input is high, the control word is cleared to 0 on each clock. This takes priority over a write in the same cycle.
- R10: While the module standby input is high and the chip standby input is low, the control word keeps its value and writes are ignored.
- R11: With the single address input high, the device-side qualifier picks which address is frozen. When the qualifier is 1, the destination address does not change on a strobe. When it is 0, the source address does not change, and this includes line transfers. With the single address input low, the qualifier has no effect.
- R12: With neither the load strobe nor the transfer strobe high, both addresses keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| standby | input | 1 | Chip standby; clears the control word |
| mod_standby | input | 1 | Module standby; freezes the control word |
| ctl_wr_en | input | 1 | Control word write enable |
| ctl_wr_data | input | 32 | Control word write data |
| ctl_rd_data | output | 32 | Control word read data; upper 16 bits are zero |
| ld_en | input | 1 | Load both addresses |
| ld_src | input | 32 | Source address load value |
| ld_dst | input | 32 | Destination address load value |
| xfer_stb | input | 1 | One transfer unit has completed |
| sngl_addr | input | 1 | Single address transfer mode |
| ack_dev_dst | input | 1 | In single address mode: 1 means the acknowledged device is the destination, 0 means it is the source |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |

## Verification
The assertions assume that the inputs are sampled only after the internal reset release. They also assume that a transfer strobe that coincides with a load is ignored. The line-step and fixed-mode properties read the size and mode from the control read port in the same cycle as the strobe. This means the control word seen there is the one applied to that step. The stimulus drives every input once per cycle on the falling edge. It waits several cycles after reset before it issues any command, and it changes the control word only in cycles without a strobe. A behavioural model then tracks every cycle, including the cycles that mix a load with a strobe.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;
  localparam int CTL_W   = 32;
  localparam int VALID_W = 16;
  localparam int DM_LSB  = 14;
  localparam int SM_LSB  = 12;
  localparam int SZ_LSB  = 10;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_RSVD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  typedef struct packed {
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
    xfer_size_e size;
  } step_cfg_t;
endpackage

// File: rtl/dma_step_ctrl.sv
module dma_step_ctrl
  import dma_step_pkg::*;
#(
  parameter int CW = CTL_W,
  parameter int VW = VALID_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          mod_standby,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output step_cfg_t     cfg
);
  localparam int PAD_W = CW - VW;

  logic [VW-1:0] ctl_q;
  logic [VW-1:0] ctl_nxt;
  logic          ctl_en;

  always_comb begin
    ctl_nxt = ctl_q;
    ctl_en  = 1'b0;
    if (standby) begin
      ctl_nxt = '0;
      ctl_en  = 1'b1;
    end else if (wr_en && !mod_standby) begin
      ctl_nxt = wr_data[VW-1:0];
      ctl_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_nxt;
    end
  end

  assign rd_data      = {{PAD_W{1'b0}}, ctl_q};
  assign cfg.dst_mode = addr_mode_e'(ctl_q[DM_LSB+1:DM_LSB]);
  assign cfg.src_mode = addr_mode_e'(ctl_q[SM_LSB+1:SM_LSB]);
  assign cfg.size     = xfer_size_e'(ctl_q[SZ_LSB+1:SZ_LSB]);
endmodule

// File: rtl/dma_step_calc.sv
module dma_step_calc
  import dma_step_pkg::*;
#(
  parameter int AW         = 32,
  parameter bit LINE_FORCE = 1'b0
) (
  input  logic [AW-1:0] cur,
  input  addr_mode_e    mode,
  input  xfer_size_e    size,
  input  logic          hold,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] mag;
  logic          line_adv;

  always_comb begin
    unique case (size)
      SZ_BYTE: mag = AW'(1);
      SZ_WORD: mag = AW'(2);
      SZ_LONG: mag = AW'(4);
      default: mag = AW'(16);
    endcase
  end

  generate
    if (LINE_FORCE) begin : g_line
      assign line_adv = (size == SZ_LINE);
    end else begin : g_noline
      assign line_adv = 1'b0;
    end
  endgenerate

  always_comb begin
    if (hold) begin
      nxt = cur;
    end else if (line_adv) begin
      nxt = cur + mag;
    end else begin
      unique case (mode)
        AM_INC:  nxt = cur + mag;
        AM_DEC:  nxt = cur - mag;
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/dma_step_areg.sv
module dma_step_areg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_val,
  input  logic          stb,
  input  logic [AW-1:0] step_val,
  output logic [AW-1:0] q
);
  logic          a_en;
  logic [AW-1:0] a_nxt;

  always_comb begin
    a_en  = ld_en | stb;
    a_nxt = ld_en ? ld_val : step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (a_en) begin
      q <= a_nxt;
    end
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_step_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          mod_standby,
  input  logic          ctl_wr_en,
  input  logic [31:0]   ctl_wr_data,
  output logic [31:0]   ctl_rd_data,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic          xfer_stb,
  input  logic          sngl_addr,
  input  logic          ack_dev_dst,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  localparam int NSIDE = 2;
  localparam int S_SRC = 0;
  localparam int S_DST = 1;

  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe[1];

  step_cfg_t cfg;

  dma_step_ctrl #(.CW(CTL_W), .VW(VALID_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .standby     (standby),
    .mod_standby (mod_standby),
    .wr_en       (ctl_wr_en),
    .wr_data     (ctl_wr_data),
    .rd_data     (ctl_rd_data),
    .cfg         (cfg)
  );

  addr_mode_e        side_mode [NSIDE];
  logic              side_hold [NSIDE];
  logic [AW-1:0]     side_ld   [NSIDE];
  logic [AW-1:0]     side_cur  [NSIDE];
  logic [AW-1:0]     side_nxt  [NSIDE];

  always_comb begin
    side_mode[S_SRC] = cfg.src_mode;
    side_mode[S_DST] = cfg.dst_mode;
    side_hold[S_SRC] = sngl_addr & ~ack_dev_dst;
    side_hold[S_DST] = sngl_addr &  ack_dev_dst;
    side_ld[S_SRC]   = ld_src;
    side_ld[S_DST]   = ld_dst;
  end

  generate
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
      dma_step_calc #(.AW(AW), .LINE_FORCE(g == S_SRC)) u_calc (
        .cur  (side_cur[g]),
        .mode (side_mode[g]),
        .size (cfg.size),
        .hold (side_hold[g]),
        .nxt  (side_nxt[g])
      );
      dma_step_areg #(.AW(AW)) u_areg (
        .clk      (clk),
        .rst_n    (rst_n_sync),
        .ld_en    (ld_en),
        .ld_val   (side_ld[g]),
        .stb      (xfer_stb),
        .step_val (side_nxt[g]),
        .q        (side_cur[g])
      );
    end
  endgenerate

  assign src_addr = side_cur[S_SRC];
  assign dst_addr = side_cur[S_DST];
endmodule

// File: rtl/dma_addr_step_chk.sv
module dma_addr_step_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        standby,
  input logic        mod_standby,
  input logic        ctl_wr_en,
  input logic [31:0] ctl_wr_data,
  input logic [31:0] ctl_rd_data,
  input logic        ld_en,
  input logic [31:0] ld_src,
  input logic [31:0] ld_dst,
  input logic        xfer_stb,
  input logic        sngl_addr,
  input logic        ack_dev_dst,
  input logic [31:0] src_addr,
  input logic [31:0] dst_addr
);
  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    (ctl_wr_en && !standby && !mod_standby) |=> ctl_rd_data == {16'h0, $past(ctl_wr_data[15:0])}); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_ok)
    ld_en |=> (src_addr == $past(ld_src)) && (dst_addr == $past(ld_dst))); // R3
  AST_DST_FIXED: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ld_en && xfer_stb && (ctl_rd_data[15:14] == 2'b00 || ctl_rd_data[15:14] == 2'b11)) |=> $stable(dst_addr)); // R4
  AST_SRC_LINE: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ld_en && xfer_stb && ctl_rd_data[11:10] == 2'b11 && !(sngl_addr && !ack_dev_dst)) |=> src_addr == $past(src_addr) + 32'd16); // R7
  AST_STBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok)
    standby |=> ctl_rd_data == 32'h0); // R9
  AST_MSTBY_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (mod_standby && !standby) |=> $stable(ctl_rd_data)); // R10
  AST_SAM_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ld_en && xfer_stb && sngl_addr && ack_dev_dst) |=> $stable(dst_addr)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ld_en && !xfer_stb) |=> $stable(src_addr) && $stable(dst_addr)); // R12
endmodule

bind dma_addr_step dma_addr_step_chk u_chk (
  .clk         (clk),
  .rst_ok      (rst_n_sync),
  .standby     (standby),
  .mod_standby (mod_standby),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_wr_data (ctl_wr_data),
  .ctl_rd_data (ctl_rd_data),
  .ld_en       (ld_en),
  .ld_src      (ld_src),
  .ld_dst      (ld_dst),
  .xfer_stb    (xfer_stb),
  .sngl_addr   (sngl_addr),
  .ack_dev_dst (ack_dev_dst),
  .src_addr    (src_addr),
  .dst_addr    (dst_addr)
);

// File: tb/dma_addr_step_test.sv
module dma_addr_step_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0, mod_standby = 1'b0, ctl_wr_en = 1'b0;
  logic [31:0] ctl_wr_data = '0;
  logic        ld_en = 1'b0, xfer_stb = 1'b0, sngl_addr = 1'b0, ack_dev_dst = 1'b0;
  logic [31:0] ld_src = '0, ld_dst = '0;
  logic [31:0] ctl_rd_data, src_addr, dst_addr;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [15:0] m_ctl;
  logic [31:0] m_src, m_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_step uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .mod_standby(mod_standby),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .ld_en(ld_en), .ld_src(ld_src), .ld_dst(ld_dst), .xfer_stb(xfer_stb),
    .sngl_addr(sngl_addr), .ack_dev_dst(ack_dev_dst),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  function automatic logic [31:0] mdl_next(logic [31:0] a, int mode, int size, bit is_src, bit hold);
    logic [31:0] mag;
    mag = (size == 3) ? 32'd16 : (32'd1 << size);
    if (hold) return a;
    if (is_src && size == 3) return a + mag;
    if (mode == 1) return a + mag;
    if (mode == 2) return a - mag;
    return a;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = '0; m_src = '0; m_dst = '0;
    end else begin
      if (ld_en) begin
        m_src = ld_src; m_dst = ld_dst;
      end else if (xfer_stb) begin
        m_src = mdl_next(m_src, int'(m_ctl[13:12]), int'(m_ctl[11:10]), 1'b1, sngl_addr && !ack_dev_dst);
        m_dst = mdl_next(m_dst, int'(m_ctl[15:14]), int'(m_ctl[11:10]), 1'b0, sngl_addr && ack_dev_dst);
      end
      if (standby) m_ctl = '0;
      else if (ctl_wr_en && !mod_standby) m_ctl = ctl_wr_data[15:0];
    end
  end

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (started) begin
      check({cur_req, " model ctl"}, ctl_rd_data, {16'h0, m_ctl});
      check({cur_req, " model src"}, src_addr, m_src);
      check({cur_req, " model dst"}, dst_addr, m_dst);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_ctl(logic [31:0] v);
    ctl_wr_en = 1'b1; ctl_wr_data = v; cyc(); ctl_wr_en = 1'b0;
  endtask

  task automatic load(logic [31:0] s, logic [31:0] d);
    ld_en = 1'b1; ld_src = s; ld_dst = d; cyc(); ld_en = 1'b0;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      xfer_stb = 1'b1; cyc();
    end
    xfer_stb = 1'b0;
  endtask

  function automatic logic [31:0] cw(int dm, int sm, int sz);
    return 32'((dm << 14) | (sm << 12) | (sz << 10));
  endfunction

  initial begin
    cyc(); cyc(); cyc();
    rst_n = 1'b1;
    cyc(); cyc(); cyc(); cyc();
    started = 1'b1;

    cur_req = "R1";
    check("R1 ctl reset", ctl_rd_data, 32'h0);
    check("R1 src reset", src_addr, 32'h0);
    check("R1 dst reset", dst_addr, 32'h0);

    cur_req = "R2";
    wr_ctl(32'hFFFF_A5C3);
    check("R2 upper zero readback", ctl_rd_data, 32'h0000_A5C3);

    cur_req = "R3";
    ctl_wr_data = cw(1, 1, 2); wr_ctl(ctl_wr_data);
    xfer_stb = 1'b1; load(32'h0000_1000, 32'h0000_2000); xfer_stb = 1'b0;
    check("R3 load over strobe src", src_addr, 32'h0000_1000);
    check("R3 load over strobe dst", dst_addr, 32'h0000_2000);

    cur_req = "R4";
    wr_ctl(cw(2, 0, 2)); strobe(1);
    check("R4 dst dec long", dst_addr, 32'h0000_1FFC);
    check("R5 src fixed long", src_addr, 32'h0000_1000);
    wr_ctl(cw(3, 3, 0)); strobe(2);
    check("R4 dst reserved holds", dst_addr, 32'h0000_1FFC);
    check("R5 src reserved holds", src_addr, 32'h0000_1000);
    for (int dm = 0; dm < 4; dm++) begin
      for (int sz = 0; sz < 4; sz++) begin
        cur_req = "R4/R6";
        wr_ctl(cw(dm, 1, sz)); strobe(3);
      end
    end

    cur_req = "R5";
    load(32'h0000_8000, 32'h0000_9000);
    wr_ctl(cw(0, 1, 1)); strobe(1);
    check("R5 src inc word", src_addr, 32'h0000_8002);
    check("R6 dst fixed word", dst_addr, 32'h0000_9000);
    wr_ctl(cw(0, 2, 0)); strobe(1);
    check("R6 src dec byte", src_addr, 32'h0000_8001);
    for (int sm = 0; sm < 4; sm++) begin
      for (int sz = 0; sz < 3; sz++) begin
        wr_ctl(cw(1, sm, sz)); strobe(2);
      end
    end

    cur_req = "R7";
    load(32'h0000_4000, 32'h0000_5000);
    for (int sm = 0; sm < 4; sm++) begin
      wr_ctl(cw(2, sm, 3)); strobe(1);
      check("R7 line src +16", src_addr, 32'h0000_4000 + 32'((sm + 1) * 16));
    end
    check("R7 line dst dec 16", dst_addr, 32'h0000_5000 - 32'd64);

    cur_req = "R8";
    load(32'hFFFF_FFFE, 32'h0000_0001);
    wr_ctl(cw(2, 1, 2)); strobe(1);
    check("R8 src wrap up", src_addr, 32'h0000_0002);
    check("R8 dst wrap down", dst_addr, 32'hFFFF_FFFD);

    cur_req = "R9";
    wr_ctl(32'h0000_7777);
    standby = 1'b1; ctl_wr_en = 1'b1; ctl_wr_data = 32'h0000_1234; cyc();
    standby = 1'b0; ctl_wr_en = 1'b0;
    check("R9 standby clears over write", ctl_rd_data, 32'h0);

    cur_req = "R10";
    wr_ctl(32'h0000_5400);
    mod_standby = 1'b1; wr_ctl(32'h0000_AAAA); cyc();
    check("R10 module standby ignores write", ctl_rd_data, 32'h0000_5400);
    mod_standby = 1'b0;

    cur_req = "R11";
    load(32'h0000_0100, 32'h0000_0200);
    wr_ctl(cw(1, 1, 2));
    sngl_addr = 1'b1; ack_dev_dst = 1'b1; strobe(1);
    check("R11 dst held src steps", dst_addr, 32'h0000_0200);
    check("R11 src steps", src_addr, 32'h0000_0104);
    ack_dev_dst = 1'b0; wr_ctl(cw(1, 1, 3)); strobe(1);
    check("R11 src held in line", src_addr, 32'h0000_0104);
    check("R11 dst steps line", dst_addr, 32'h0000_0210);
    sngl_addr = 1'b0; ack_dev_dst = 1'b1; strobe(1);
    check("R11 no effect when not single", dst_addr, 32'h0000_0220);
    ack_dev_dst = 1'b0;

    cur_req = "R12";
    cyc(); cyc(); cyc();
    check("R12 idle src", src_addr, 32'h0000_0114);
    check("R12 idle dst", dst_addr, 32'h0000_0220);

    cyc();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule